// File: doc/BRIEF.md
# Single-Channel Direct-Mode DMA Engine

This block is one DMA channel that copies data without descriptors. Software programs the channel through a 32-bit register port. It writes a source address, a destination address, a count of transfer units, a request selector and a command word, and then sets the channel enable bit. For the channel to move any data, the controller-wide enable bit must also be set.

The engine breaks each unit into beats of at most four bytes. Each beat is one read on a generic memory master port, followed by one write of the same data. After each beat the engine steps either address when the command word asks for it. It decrements the count once per finished unit. When the count reaches zero it stops, records completion in sticky status flags and can raise a level interrupt.

A bus error, an illegal unit size or loss of enable between units also stops the channel and leaves a sticky flag behind. The channel cannot start again until software clears that flag.

Top module: `dmach_engine`

## Requirements
- R1: Byte offsets on the register port are: source 0x00, destination 0x04, unit count 0x08, request selector 0x0C, control/status 0x10, command 0x14, descriptor pointer 0x18 (stored only) and controller control 0x20 (bit0 is the global enable). After reset every register reads zero, and the written values read back.
- R2: Data moves only when all of these hold: the global enable is set, control/status bit0 (channel enable) is set, control/status bit31 (direct mode) is set, and flags bit2, bit3 and bit4 are all clear.
- R3: Command bits 10:8 select the unit size: 0 is 4 bytes, 1 is 1 byte, 2 is 2 bytes, 3 is 16 bytes and 4 is 32 bytes. The count register holds units, not bytes, and reads back the units still remaining.
- R4: Command bit23 makes the source address step and bit22 makes the destination address step. Each enabled address advances by the beat size after every beat. The destination receives the bytes that the stepped source sequence supplies.
- R5: When the last unit completes, the engine clears channel enable and sets bit3 (transfer end) and bit1 (count terminated) in the same cycle. If the count is zero at start, the engine sets both flags at once and makes no bus access.
- R6: The interrupt output equals the transfer-end flag gated by command bit1. The flag is set whether or not the interrupt is enabled.
- R7: An error response on the memory port sets bit4 (address error) and clears channel enable. No further bus access follows, and the count keeps the units that did not complete.
- R8: Unit size codes 5 to 7 set bit4 and clear channel enable without any bus access.
- R9: Only a software write to control/status clears bits 2, 3 and 4. While any of them is set, setting the enable bit does not move data.
- R10: If the channel enable or the global enable is removed between units, the engine sets bit2 (halt), clears channel enable and leaves the remaining count intact.
- R11: A request selector of zero runs units back to back. Any other value makes every unit wait for the request input. After each unit's final write completes, the acknowledge output pulses for one cycle.
- R12: A 16-byte unit is 4 beats of 4 bytes and a 32-byte unit is 8 beats. Each beat is one read and then one write of the read data. The size code on the port is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. The engine holds a request stable until ready or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| memValid | output | 1 | Bus request valid |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Bus byte address |
| memSize | output | 2 | Beat size code |
| memWdata | output | 32 | Write data, right aligned |
| memRdata | input | 32 | Read data, right aligned |
| memReady | input | 1 | Beat accepted |
| memError | input | 1 | Beat failed |
| periphReq | input | 1 | Peripheral unit request |
| periphAck | output | 1 | Unit-done acknowledge pulse |
| irq | output | 1 | Level interrupt |

## Verification
The assertions watch the properties that hold on every cycle. They check that a pending bus request stays stable, that no access follows an error response, and that the acknowledge is a single-cycle pulse tied to a completed write. They also check that the count only ever drops by one, that the error and end flags stay set until software writes them, and that the end flag and the enable bit change together. Only the bench scenarios can show the rest. These are the byte-exact destination contents for every size and stepping mode, the final addresses, the beat count per unit, and the blocking of a restart by stale flags. They also cover the halt between peripheral requests and the absence of any bus access under illegal sizes or missing enables.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int ADDR_W = 6;

  typedef logic [3:0] wordIdx_t;
  localparam wordIdx_t IDX_SRC    = 4'd0;
  localparam wordIdx_t IDX_DST    = 4'd1;
  localparam wordIdx_t IDX_CNT    = 4'd2;
  localparam wordIdx_t IDX_REQ    = 4'd3;
  localparam wordIdx_t IDX_CSR    = 4'd4;
  localparam wordIdx_t IDX_CMD    = 4'd5;
  localparam wordIdx_t IDX_DESC   = 4'd6;
  localparam wordIdx_t IDX_GLOBAL = 4'd8;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_READ, ST_WRITE} state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic ldData;
    logic stepBeat;
    logic setEnd;
    logic setErr;
    logic setHalt;
    logic selDst;
  } strobe_t;

  typedef struct packed {
    logic       ok;
    logic [1:0] beatLog2;
    logic [2:0] lastBeat;
  } unit_t;

  function automatic unit_t decodeUnit(input logic [2:0] code);
    unit_t u;
    u.ok = 1'b1;
    u.beatLog2 = 2'd2;
    u.lastBeat = 3'd0;
    case (code)
      3'd0: u.beatLog2 = 2'd2;
      3'd1: u.beatLog2 = 2'd0;
      3'd2: u.beatLog2 = 2'd1;
      3'd3: u.lastBeat = 3'd3;
      3'd4: u.lastBeat = 3'd7;
      default: u.ok = 1'b0;
    endcase
    return u;
  endfunction
endpackage

// File: rtl/dmach_datapath.sv
module dmach_datapath
  import dmach_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int REQ_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  strobe_t           strobe,
  input  logic [31:0]       memRdata,
  output logic [31:0]       memAddr,
  output logic [1:0]        memSize,
  output logic [31:0]       memWdata,
  output logic              runOk,
  output logic              sizeBad,
  output logic              cntZero,
  output logic              cntOne,
  output logic              lastBeat,
  output logic              autoReq,
  output logic              irq,
  output logic [CNT_W-1:0]  cntVal,
  output logic              flagErr,
  output logic              flagEnd,
  output logic              chanEn
);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [2:0]       BEAT_ONE = 3'd1;

  logic [31:0]      srcAddr, dstAddr, cmdWord, descAddr, dataReg, beatBytes;
  logic [REQ_W-1:0] reqType;
  logic             flagCt, flagHalt, noDesc, globalEn;
  logic [2:0]       beatIdx;
  unit_t            unitInfo;
  wordIdx_t         idx;
  logic             aligned, unitDone, stopNow;
  logic             wrSrc, wrDst, wrCnt, wrReq, wrCsr, wrCmd, wrDesc, wrGlb;

  assign idx      = regAddr[ADDR_W-1:2];
  assign aligned  = (regAddr[1:0] == 2'b00);
  assign wrSrc    = regWrite && aligned && idx == IDX_SRC;
  assign wrDst    = regWrite && aligned && idx == IDX_DST;
  assign wrCnt    = regWrite && aligned && idx == IDX_CNT;
  assign wrReq    = regWrite && aligned && idx == IDX_REQ;
  assign wrCsr    = regWrite && aligned && idx == IDX_CSR;
  assign wrCmd    = regWrite && aligned && idx == IDX_CMD;
  assign wrDesc   = regWrite && aligned && idx == IDX_DESC;
  assign wrGlb    = regWrite && aligned && idx == IDX_GLOBAL;

  assign unitInfo = decodeUnit(cmdWord[10:8]);
  assign sizeBad  = !unitInfo.ok;
  assign lastBeat = (beatIdx == unitInfo.lastBeat);
  assign unitDone = strobe.stepBeat && lastBeat;
  assign stopNow  = strobe.setEnd || strobe.setErr || strobe.setHalt;
  assign memSize  = unitInfo.beatLog2;
  assign memAddr  = strobe.selDst ? dstAddr : srcAddr;
  assign memWdata = dataReg;
  assign runOk    = globalEn && chanEn && noDesc && !flagHalt && !flagErr && !flagEnd;
  assign cntZero  = (cntVal == '0);
  assign cntOne   = (cntVal == CNT_ONE);
  assign autoReq  = (reqType == '0);
  assign irq      = flagEnd && cmdWord[1];

  always_comb begin
    beatBytes = '0;
    beatBytes[unitInfo.beatLog2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      cntVal   <= '0;
      reqType  <= '0;
      cmdWord  <= '0;
      descAddr <= '0;
      globalEn <= 1'b0;
      dataReg  <= '0;
      beatIdx  <= '0;
    end else begin
      if (wrSrc) srcAddr <= regWdata;
      else if (strobe.stepBeat && cmdWord[23]) srcAddr <= srcAddr + beatBytes;
      if (wrDst) dstAddr <= regWdata;
      else if (strobe.stepBeat && cmdWord[22]) dstAddr <= dstAddr + beatBytes;
      if (wrCnt) cntVal <= regWdata[CNT_W-1:0];
      else if (unitDone) cntVal <= cntVal - CNT_ONE;
      if (wrReq)  reqType  <= regWdata[REQ_W-1:0];
      if (wrCmd)  cmdWord  <= regWdata;
      if (wrDesc) descAddr <= regWdata;
      if (wrGlb)  globalEn <= regWdata[0];
      if (strobe.ldData) dataReg <= memRdata;
      if (stopNow) beatIdx <= '0;
      else if (strobe.stepBeat) beatIdx <= lastBeat ? 3'd0 : beatIdx + BEAT_ONE;
    end
  end

  // status word: software write first, engine events override
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanEn   <= 1'b0;
      flagCt   <= 1'b0;
      flagHalt <= 1'b0;
      flagEnd  <= 1'b0;
      flagErr  <= 1'b0;
      noDesc   <= 1'b0;
    end else begin
      if (wrCsr) begin
        chanEn   <= regWdata[0];
        flagCt   <= regWdata[1];
        flagHalt <= regWdata[2];
        flagEnd  <= regWdata[3];
        flagErr  <= regWdata[4];
        noDesc   <= regWdata[31];
      end
      if (strobe.setEnd) begin
        chanEn  <= 1'b0;
        flagEnd <= 1'b1;
        flagCt  <= 1'b1;
      end
      if (strobe.setErr) begin
        chanEn  <= 1'b0;
        flagErr <= 1'b1;
      end
      if (strobe.setHalt) begin
        chanEn   <= 1'b0;
        flagHalt <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (aligned) begin
      case (idx)
        IDX_SRC:    regRdata = srcAddr;
        IDX_DST:    regRdata = dstAddr;
        IDX_CNT:    regRdata[CNT_W-1:0] = cntVal;
        IDX_REQ:    regRdata[REQ_W-1:0] = reqType;
        IDX_CSR:    regRdata = {noDesc, 26'd0, flagErr, flagEnd, flagHalt, flagCt, chanEn};
        IDX_CMD:    regRdata = cmdWord;
        IDX_DESC:   regRdata = descAddr;
        IDX_GLOBAL: regRdata[0] = globalEn;
        default:    regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    runOk,
  input  logic    sizeBad,
  input  logic    cntZero,
  input  logic    cntOne,
  input  logic    lastBeat,
  input  logic    autoReq,
  input  logic    periphReq,
  input  logic    memReady,
  input  logic    memError,
  output logic    memValid,
  output logic    memWrite,
  output logic    periphAck,
  output strobe_t strobe
);
  state_t state, nextState;
  logic   ackNext;

  always_comb begin
    strobe    = '0;
    nextState = state;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    ackNext   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (runOk) begin
          if (sizeBad)      strobe.setErr = 1'b1;
          else if (cntZero) strobe.setEnd = 1'b1;
          else              nextState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!runOk) begin
          strobe.setHalt = 1'b1;
          nextState = ST_IDLE;
        end else if (autoReq || periphReq) begin
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        memValid = 1'b1;
        if (memError) begin
          strobe.setErr = 1'b1;
          nextState = ST_IDLE;
        end else if (memReady) begin
          strobe.ldData = 1'b1;
          nextState = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        strobe.selDst = 1'b1;
        if (memError) begin
          strobe.setErr = 1'b1;
          nextState = ST_IDLE;
        end else if (memReady) begin
          strobe.stepBeat = 1'b1;
          if (!lastBeat) begin
            nextState = ST_READ;
          end else begin
            ackNext = !autoReq;
            if (cntOne) begin
              strobe.setEnd = 1'b1;
              nextState = ST_IDLE;
            end else begin
              nextState = ST_WAIT;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      periphAck <= 1'b0;
    end else begin
      state     <= nextState;
      periphAck <= ackNext;
    end
  end
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
  import dmach_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int REQ_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [31:0]       memAddr,
  output logic [1:0]        memSize,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memReady,
  input  logic              memError,
  input  logic              periphReq,
  output logic              periphAck,
  output logic              irq
);
  strobe_t          strobe;
  logic             runOk, sizeBad, cntZero, cntOne, lastBeat, autoReq;
  logic [CNT_W-1:0] cntVal;
  logic             flagErr, flagEnd, chanEn;

  dmach_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .runOk(runOk), .sizeBad(sizeBad), .cntZero(cntZero), .cntOne(cntOne),
    .lastBeat(lastBeat), .autoReq(autoReq), .periphReq(periphReq),
    .memReady(memReady), .memError(memError),
    .memValid(memValid), .memWrite(memWrite), .periphAck(periphAck),
    .strobe(strobe)
  );

  dmach_datapath #(.CNT_W(CNT_W), .REQ_W(REQ_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .memRdata(memRdata),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata),
    .runOk(runOk), .sizeBad(sizeBad), .cntZero(cntZero), .cntOne(cntOne),
    .lastBeat(lastBeat), .autoReq(autoReq), .irq(irq),
    .cntVal(cntVal), .flagErr(flagErr), .flagEnd(flagEnd), .chanEn(chanEn)
  );
endmodule

// File: rtl/dmach_checker.sv
module dmach_checker
  import dmach_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic              memValid,
  input logic              memWrite,
  input logic              memReady,
  input logic              memError,
  input logic [31:0]       memAddr,
  input logic [1:0]        memSize,
  input logic              periphAck,
  input logic              irq,
  input logic [CNT_W-1:0]  cntVal,
  input logic              flagErr,
  input logic              flagEnd,
  input logic              chanEn
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic csrWr, cntWr;
  assign csrWr = regWrite && regAddr[1:0] == 2'b00 && regAddr[ADDR_W-1:2] == IDX_CSR;
  assign cntWr = regWrite && regAddr[1:0] == 2'b00 && regAddr[ADDR_W-1:2] == IDX_CNT;

  assert_hold_until_ready_R12: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady && !memError |=> memValid && $stable(memAddr) && $stable(memWrite));

  assert_size_legal_R12: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> memSize != 2'd3);

  assert_err_stops_R7: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memError |=> !memValid);

  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    periphAck |=> !periphAck);

  assert_ack_after_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    periphAck |-> $past(memValid && memWrite && memReady && !memError));

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !memValid);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal != $past(cntVal)) && !$past(cntWr) |-> (cntVal + ONE) == $past(cntVal));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    flagErr && !csrWr |=> flagErr);

  assert_end_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    flagEnd && !csrWr |=> flagEnd);

  assert_end_disables_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagEnd) && !$past(csrWr) |-> !chanEn);
endmodule

bind dmach_engine dmach_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
  .memValid(memValid), .memWrite(memWrite), .memReady(memReady), .memError(memError),
  .memAddr(memAddr), .memSize(memSize), .periphAck(periphAck), .irq(irq),
  .cntVal(cntVal), .flagErr(flagErr), .flagEnd(flagEnd), .chanEn(chanEn)
);

// File: tb/dmach_engine_tb_top.sv
`timescale 1ns/1ps
module dmach_engine_tb_top;
  localparam int MEM_BYTES = 512;
  localparam logic [5:0] A_SRC = 6'h00, A_DST = 6'h04, A_CNT = 6'h08, A_REQ = 6'h0C,
                         A_CSR = 6'h10, A_CMD = 6'h14, A_DESC = 6'h18, A_GLB = 6'h20;
  localparam logic [31:0] SRC_BASE = 32'h0000_0000, DST_BASE = 32'h0000_0100;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrite = 1'b0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic memValid, memWrite, memReady, memError, periphAck, irq;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [1:0] memSize;
  logic periphReq = 1'b0;
  logic stallEn = 1'b0, phase = 1'b0;
  logic [7:0] mem [MEM_BYTES];
  logic [7:0] expMem [MEM_BYTES];
  int testCount = 0, failCount = 0, busCycles = 0, ackCount = 0;
  bit done = 0;

  dmach_engine dut_i (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memSize(memSize), .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .memError(memError), .periphReq(periphReq), .periphAck(periphAck), .irq(irq)
  );

  always #5 clk = ~clk;

  assign memError = memValid && memAddr[31];
  assign memReady = memValid && !memAddr[31] && !(stallEn && phase);

  always_comb begin
    for (int k = 0; k < 4; k++)
      memRdata[8*k +: 8] = mem[(int'(memAddr[8:0]) + k) % MEM_BYTES];
  end

  always @(posedge clk) begin
    phase <= ~phase;
    if (memValid && memReady && memWrite)
      for (int k = 0; k < (1 << memSize); k++)
        mem[(int'(memAddr[8:0]) + k) % MEM_BYTES] <= memWdata[8*k +: 8];
    if (memValid && (memReady || memError)) busCycles++;
    if (periphAck) ackCount++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    bit ok = 0;
    for (int i = 0; i < 3000; i++) begin
      regRd(A_CSR, v);
      if (!v[0]) begin ok = 1; break; end
    end
    if (!ok) check("R5 channel never stopped", 32'd1, 32'd0);
  endtask

  function automatic int unitBytes(input int code);
    case (code)
      0: return 4;
      1: return 1;
      2: return 2;
      3: return 16;
      default: return 32;
    endcase
  endfunction

  task automatic runCase(input int code, input bit sInc, input bit dInc, input int units, input bit tie);
    int ub, bb, beats, s, d, bad, bus0;
    logic [31:0] v;
    ub = unitBytes(code);
    bb = (ub >= 4) ? 4 : ub;
    beats = ub / bb;
    @(negedge clk);
    for (int i = 0; i < MEM_BYTES; i++) begin
      mem[i] <= (i < 256) ? 8'((i * 13 + code * 5 + units) & 255) : 8'h00;
      expMem[i] = (i < 256) ? 8'((i * 13 + code * 5 + units) & 255) : 8'h00;
    end
    for (int u = 0; u < units; u++)
      for (int b = 0; b < beats; b++) begin
        s = int'(SRC_BASE) + (sInc ? (u * beats + b) * bb : 0);
        d = int'(DST_BASE) + (dInc ? (u * beats + b) * bb : 0);
        for (int j = 0; j < bb; j++) expMem[d + j] = expMem[s + j];
      end
    regWr(A_SRC, SRC_BASE);
    regWr(A_DST, DST_BASE);
    regWr(A_CNT, 32'(units));
    regWr(A_CMD, (32'(sInc) << 23) | (32'(dInc) << 22) | (32'h2 << 14) | (32'h2 << 12)
                 | (32'(code) << 8) | (32'(tie) << 1));
    bus0 = busCycles;
    regWr(A_CSR, 32'h8000_0001);
    waitIdle();
    bad = 0;
    for (int i = 256; i < MEM_BYTES; i++) if (mem[i] !== expMem[i]) bad++;
    check("R4 destination bytes mismatched", 32'(bad), 32'd0);
    check("R12 bus beats per transfer", 32'(busCycles - bus0), 32'(2 * units * beats));
    regRd(A_CNT, v);  check("R3 remaining units", v, 32'd0);
    regRd(A_CSR, v);  check("R5 status at end", v, 32'h8000_000A);
    regRd(A_SRC, v);  check("R4 final source", v, SRC_BASE + (sInc ? 32'(units * ub) : 32'd0));
    regRd(A_DST, v);  check("R4 final destination", v, DST_BASE + (dInc ? 32'(units * ub) : 32'd0));
    @(negedge clk);   check("R6 interrupt gated by enable bit", 32'(irq), 32'(tie));
    regWr(A_CSR, 32'h0);
    @(negedge clk);   check("R6 interrupt clears with flag", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testCount++; failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int bus0, ack0;
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values and readback
    regRd(A_SRC, v); check("R1 reset source", v, 32'd0);
    regRd(A_CNT, v); check("R1 reset count", v, 32'd0);
    regRd(A_CSR, v); check("R1 reset status", v, 32'd0);
    regRd(A_CMD, v); check("R1 reset command", v, 32'd0);
    regRd(A_GLB, v); check("R1 reset global", v, 32'd0);
    check("R1 reset irq", 32'(irq), 32'd0);
    check("R1 reset bus idle", 32'(memValid), 32'd0);
    regWr(A_REQ, 32'h0000_002A);  regRd(A_REQ, v);  check("R1 request readback", v, 32'h2A);
    regWr(A_CMD, 32'h00C0_5A02);  regRd(A_CMD, v);  check("R1 command readback", v, 32'h00C0_5A02);
    regWr(A_DESC, 32'h1234_5670); regRd(A_DESC, v); check("R1 descriptor readback", v, 32'h1234_5670);
    regWr(A_REQ, 32'h0);

    // R2 global enable and direct-mode bit gate the start
    regWr(A_SRC, SRC_BASE); regWr(A_DST, DST_BASE); regWr(A_CNT, 32'd2); regWr(A_CMD, 32'h00C0_0000);
    bus0 = busCycles;
    regWr(A_CSR, 32'h8000_0001);
    repeat (10) @(negedge clk);
    check("R2 no traffic without global enable", 32'(busCycles - bus0), 32'd0);
    regRd(A_CNT, v); check("R2 count untouched without global enable", v, 32'd2);
    regWr(A_CSR, 32'h0000_0001);
    regWr(A_GLB, 32'h1);
    repeat (10) @(negedge clk);
    check("R2 no traffic without direct-mode bit", 32'(busCycles - bus0), 32'd0);
    regWr(A_CSR, 32'h8000_0001);
    waitIdle();
    regRd(A_CNT, v); check("R2 runs once all enables set", v, 32'd0);
    check("R2 beats after enable", 32'(busCycles - bus0), 32'd4);

    // R9 restart blocked by stale end flag
    regWr(A_CNT, 32'd2);
    bus0 = busCycles;
    regWr(A_CSR, 32'h8000_0009);
    repeat (10) @(negedge clk);
    check("R9 end flag blocks restart", 32'(busCycles - bus0), 32'd0);
    regRd(A_CNT, v); check("R9 count kept while blocked", v, 32'd2);
    regWr(A_CSR, 32'h0);

    // R3 R4 R12 sweep over sizes, stepping modes and counts
    for (int code = 0; code < 5; code++)
      for (int mode = 0; mode < 3; mode++)
        for (int units = 1; units <= 3; units++) begin
          stallEn = (units == 2);
          runCase(code, mode != 2, mode != 1, units, mode != 1);
        end
    stallEn = 1'b0;

    // R5 zero count ends immediately
    regWr(A_CNT, 32'd0); regWr(A_CMD, 32'h00C0_0002);
    bus0 = busCycles;
    regWr(A_CSR, 32'h8000_0001);
    waitIdle();
    regRd(A_CSR, v); check("R5 zero count ends at once", v, 32'h8000_000A);
    check("R5 zero count no bus access", 32'(busCycles - bus0), 32'd0);
    check("R6 zero count interrupt", 32'(irq), 32'd1);
    regWr(A_CSR, 32'h0);

    // R8 illegal size codes
    for (int code = 5; code < 8; code++) begin
      regWr(A_CNT, 32'd2); regWr(A_CMD, 32'h00C0_0000 | (32'(code) << 8));
      bus0 = busCycles;
      regWr(A_CSR, 32'h8000_0001);
      repeat (5) @(negedge clk);
      regRd(A_CSR, v); check("R8 illegal size flags error", v, 32'h8000_0010);
      regRd(A_CNT, v); check("R8 illegal size keeps count", v, 32'd2);
      check("R8 illegal size no bus access", 32'(busCycles - bus0), 32'd0);
      regWr(A_CSR, 32'h0);
    end

    // R7 error on read, then R9 block by error flag
    regWr(A_SRC, 32'h8000_0000); regWr(A_DST, DST_BASE); regWr(A_CNT, 32'd3);
    regWr(A_CMD, 32'h00C0_0002);
    bus0 = busCycles;
    regWr(A_CSR, 32'h8000_0001);
    waitIdle();
    regRd(A_CSR, v); check("R7 read error status", v, 32'h8000_0010);
    regRd(A_CNT, v); check("R7 count after read error", v, 32'd3);
    check("R7 single access on read error", 32'(busCycles - bus0), 32'd1);
    check("R7 no interrupt on error", 32'(irq), 32'd0);
    bus0 = busCycles;
    regWr(A_CSR, 32'h8000_0011);
    repeat (10) @(negedge clk);
    check("R9 error flag blocks restart", 32'(busCycles - bus0), 32'd0);
    regWr(A_CSR, 32'h0);
    // R7 error on write
    regWr(A_SRC, SRC_BASE); regWr(A_DST, 32'h8000_0100);
    bus0 = busCycles;
    regWr(A_CSR, 32'h8000_0001);
    waitIdle();
    regRd(A_CSR, v); check("R7 write error status", v, 32'h8000_0010);
    regRd(A_CNT, v); check("R7 count after write error", v, 32'd3);
    check("R7 two accesses on write error", 32'(busCycles - bus0), 32'd2);
    regWr(A_CSR, 32'h0);

    // R11 R10 peripheral-paced transfer and halt between units
    regWr(A_SRC, SRC_BASE); regWr(A_DST, DST_BASE); regWr(A_CNT, 32'd2);
    regWr(A_CMD, 32'h00C0_0000); regWr(A_REQ, 32'h3);
    bus0 = busCycles; ack0 = ackCount;
    regWr(A_CSR, 32'h8000_0001);
    repeat (6) @(negedge clk);
    check("R11 waits for request", 32'(busCycles - bus0), 32'd0);
    periphReq = 1'b1;
    @(negedge clk);
    periphReq = 1'b0;
    repeat (8) @(negedge clk);
    regRd(A_CNT, v); check("R11 one unit per request", v, 32'd1);
    check("R11 one acknowledge per unit", 32'(ackCount - ack0), 32'd1);
    regWr(A_CSR, 32'h8000_0000);
    repeat (3) @(negedge clk);
    regRd(A_CSR, v); check("R10 halt flag after enable removed", v, 32'h8000_0004);
    regRd(A_CNT, v); check("R10 remaining count kept", v, 32'd1);
    bus0 = busCycles;
    periphReq = 1'b1;
    regWr(A_CSR, 32'h8000_0005);
    repeat (10) @(negedge clk);
    check("R9 halt flag blocks restart", 32'(busCycles - bus0), 32'd0);
    regWr(A_CSR, 32'h8000_0001);
    waitIdle();
    periphReq = 1'b0;
    regRd(A_CNT, v); check("R11 resumed transfer finishes", v, 32'd0);
    check("R11 total acknowledges", 32'(ackCount - ack0), 32'd2);
    regRd(A_CSR, v); check("R5 status after paced transfer", v, 32'h8000_000A);
    regWr(A_CSR, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule